// File: doc/BRIEF.md
# Oldest-First Squash Request Arbiter

During one clock cycle, several instructions finish execution on parallel lanes. Any of these lanes can raise a redirect. A lane raises one when its branch outcome differs from the prediction, or when the load/store logic has found a memory-ordering violation. The violation names a younger memory access that must be replayed. This block walks the lanes in their priority order and keeps the single oldest accepted redirect. It registers that redirect and sends it to the retirement stage one cycle later. Sequence numbers are unsigned, and a smaller number means an older instruction. The pending redirect starts empty in every cycle, so nothing carries over from one cycle to the next.

The two kinds of redirect produce different results. A branch redirect restarts fetch at the address after the branch. The branch itself survives, and its resolved direction is reported. A violation redirect restarts at the offending access's own address, and that access is squashed together with everything younger. When a branch and a violation name the same sequence number, the violation wins.

The block also keeps running counts of branch mispredictions and ordering violations. Mispredictions are split by predicted direction, and a combined total is kept as well.

Top module: `squash_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs (squash fields and every counter) become zero.
- R2: If no lane has `ln_vld` set in a cycle, `sq_valid` is 0 in the following cycle. No redirect survives from an earlier cycle.
- R3: An accepted branch redirect appears one cycle after its inputs. It gives `sq_valid`=1, `sq_seq` equal to the lane's sequence number, `sq_pc` equal to `ln_next_pc`, `sq_incl_self`=0, and `sq_br_taken` equal to `ln_act_tkn`.
- R4: An accepted violation appears one cycle after its inputs. It gives `sq_valid`=1, `sq_seq` equal to `ln_viol_seq`, `sq_pc` equal to `ln_viol_pc`, `sq_incl_self`=1 and `sq_br_taken`=0.
- R5: Lanes are evaluated from index 0 upward. A branch replaces a pending redirect only if its sequence number is strictly smaller than the pending one.
- R6: A violation replaces a pending redirect if its violator sequence number is smaller than or equal to the pending one. On a tie with a branch, the violation therefore wins.
- R7: A valid lane is examined only if no redirect is pending or the pending sequence number is strictly larger than the lane's own. A lane that is not examined never changes the redirect.
- R8: A lane with `ln_is_load`=1 and `ln_done`=0 is never treated as a misprediction, even if `ln_mispred`=1. Such a lane is not counted as one either.
- R9: An examined misprediction adds 1 to `cnt_tkn_wrong` when `ln_pred_tkn`=1, or to `cnt_ntkn_wrong` when it is 0. `cnt_mispred` always equals their sum, modulo 2^CNT_W.
- R10: `cnt_viol` adds 1 for every valid lane with `ln_viol`=1, whether or not the violation is accepted. The only exception is R11.
- R11: When an examined lane is itself a misprediction, its violation input is ignored. It is neither counted nor considered for the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_vld | input | LANES | Lane carries a completing instruction |
| ln_seq | input | LANES x SEQ_W | Lane instruction sequence number |
| ln_is_load | input | LANES | Lane instruction is a load |
| ln_done | input | LANES | Lane instruction has actually executed |
| ln_mispred | input | LANES | Branch outcome differs from prediction |
| ln_pred_tkn | input | LANES | Branch was predicted taken |
| ln_act_tkn | input | LANES | Branch resolved taken |
| ln_next_pc | input | LANES x PC_W | Address following the branch |
| ln_viol | input | LANES | Ordering violation reported with this lane |
| ln_viol_seq | input | LANES x SEQ_W | Sequence number of the violating access |
| ln_viol_pc | input | LANES x PC_W | Address of the violating access |
| sq_valid | output | 1 | A squash request is issued |
| sq_seq | output | SEQ_W | Squashing sequence number |
| sq_pc | output | PC_W | Restart address |
| sq_incl_self | output | 1 | The squashing instruction is discarded too |
| sq_br_taken | output | 1 | Resolved direction of the squashing branch |
| cnt_tkn_wrong | output | CNT_W | Mispredictions predicted taken |
| cnt_ntkn_wrong | output | CNT_W | Mispredictions predicted not taken |
| cnt_mispred | output | CNT_W | Total mispredictions |
| cnt_viol | output | CNT_W | Ordering violations seen |

## Verification
The properties assume that every lane input is a settled two-state value at each rising edge. They also assume that at most LANES events of one kind arrive in a cycle. The properties need nothing about sequence uniqueness, so colliding and out-of-order numbers are legal input. The stimulus changes inputs only at falling edges and drives every field to a known value, with idle lanes zeroed. Its random phase draws sequence numbers from a narrow range so that ties and reversals between lanes happen often.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;

    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [PC_W-1:0]  pc_t;

    // One completing instruction as seen by the arbiter
    typedef struct packed {
        logic vld;
        seq_t seq;
        logic is_load;
        logic done;
        logic mispred;
        logic pred_tkn;
        logic act_tkn;
        pc_t  next_pc;
        logic viol;
        seq_t viol_seq;
        pc_t  viol_pc;
    } lane_t;

    // Pending redirect carried along the lane chain
    typedef struct packed {
        logic valid;
        seq_t seq;
        pc_t  pc;
        logic incl_self;
        logic br_taken;
    } sq_state_t;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_BRANCH = 2'd1,
        ACT_VIOL   = 2'd2
    } stage_act_e;

    function automatic logic is_older(input seq_t a, input seq_t b);
        return a < b;
    endfunction

    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/sqarb_stage.sv
module sqarb_stage
    import sqarb_pkg::*;
(
    input  sq_state_t up,
    input  lane_t     ln,
    output sq_state_t dn,
    output logic      ev_tkn,
    output logic      ev_ntkn,
    output logic      ev_viol
);

    logic       examine;
    logic       br_hit;
    stage_act_e act;

    always_comb begin
        examine = ln.vld && (!up.valid || is_older(ln.seq, up.seq));
        br_hit  = ln.mispred && !(ln.is_load && !ln.done);
        act     = ACT_KEEP;
        if (examine && br_hit) begin
            if (!up.valid || is_older(ln.seq, up.seq)) begin
                act = ACT_BRANCH;
            end
        end else if (examine && ln.viol) begin
            if (!up.valid || !is_older(up.seq, ln.viol_seq)) begin
                act = ACT_VIOL;
            end
        end

        ev_tkn  = examine && br_hit && ln.pred_tkn;
        ev_ntkn = examine && br_hit && !ln.pred_tkn;
        ev_viol = ln.vld && ln.viol && !(examine && br_hit);

        case (act)
            ACT_BRANCH: begin
                dn.valid     = 1'b1;
                dn.seq       = ln.seq;
                dn.pc        = ln.next_pc;
                dn.incl_self = 1'b0;
                dn.br_taken  = ln.act_tkn;
            end
            ACT_VIOL: begin
                dn.valid     = 1'b1;
                dn.seq       = ln.viol_seq;
                dn.pc        = ln.viol_pc;
                dn.incl_self = 1'b1;
                dn.br_taken  = 1'b0;
            end
            default: dn = up;
        endcase
    end

endmodule

// File: rtl/sqarb_counters.sv
module sqarb_counters
    import sqarb_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] ev_tkn,
    input  logic [LANES-1:0] ev_ntkn,
    input  logic [LANES-1:0] ev_viol,
    output logic [CNT_W-1:0] cnt_tkn_wrong,
    output logic [CNT_W-1:0] cnt_ntkn_wrong,
    output logic [CNT_W-1:0] cnt_mispred,
    output logic [CNT_W-1:0] cnt_viol
);

    localparam int INC_W = $clog2(LANES + 1);

    logic [INC_W-1:0] inc_tkn, inc_ntkn, inc_all, inc_viol;

    always_comb begin
        inc_tkn  = INC_W'(ones32(32'(ev_tkn)));
        inc_ntkn = INC_W'(ones32(32'(ev_ntkn)));
        inc_all  = INC_W'(ones32(32'(ev_tkn | ev_ntkn)));
        inc_viol = INC_W'(ones32(32'(ev_viol)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_tkn_wrong  <= '0;
            cnt_ntkn_wrong <= '0;
            cnt_mispred    <= '0;
            cnt_viol       <= '0;
        end else begin
            cnt_tkn_wrong  <= cnt_tkn_wrong  + CNT_W'(inc_tkn);
            cnt_ntkn_wrong <= cnt_ntkn_wrong + CNT_W'(inc_ntkn);
            cnt_mispred    <= cnt_mispred    + CNT_W'(inc_all);
            cnt_viol       <= cnt_viol       + CNT_W'(inc_viol);
        end
    end

endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter
    import sqarb_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            ln_vld,
    input  logic [LANES-1:0][SEQ_W-1:0] ln_seq,
    input  logic [LANES-1:0]            ln_is_load,
    input  logic [LANES-1:0]            ln_done,
    input  logic [LANES-1:0]            ln_mispred,
    input  logic [LANES-1:0]            ln_pred_tkn,
    input  logic [LANES-1:0]            ln_act_tkn,
    input  logic [LANES-1:0][PC_W-1:0]  ln_next_pc,
    input  logic [LANES-1:0]            ln_viol,
    input  logic [LANES-1:0][SEQ_W-1:0] ln_viol_seq,
    input  logic [LANES-1:0][PC_W-1:0]  ln_viol_pc,
    output logic                        sq_valid,
    output logic [SEQ_W-1:0]            sq_seq,
    output logic [PC_W-1:0]             sq_pc,
    output logic                        sq_incl_self,
    output logic                        sq_br_taken,
    output logic [CNT_W-1:0]            cnt_tkn_wrong,
    output logic [CNT_W-1:0]            cnt_ntkn_wrong,
    output logic [CNT_W-1:0]            cnt_mispred,
    output logic [CNT_W-1:0]            cnt_viol
);

    lane_t            lanes [LANES];
    sq_state_t        chain [LANES+1];
    logic [LANES-1:0] ev_tkn, ev_ntkn, ev_viol;
    sq_state_t        sq_q;

    assign chain[0] = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lanes[g].vld      = ln_vld[g];
            lanes[g].seq      = ln_seq[g];
            lanes[g].is_load  = ln_is_load[g];
            lanes[g].done     = ln_done[g];
            lanes[g].mispred  = ln_mispred[g];
            lanes[g].pred_tkn = ln_pred_tkn[g];
            lanes[g].act_tkn  = ln_act_tkn[g];
            lanes[g].next_pc  = ln_next_pc[g];
            lanes[g].viol     = ln_viol[g];
            lanes[g].viol_seq = ln_viol_seq[g];
            lanes[g].viol_pc  = ln_viol_pc[g];
        end

        sqarb_stage stage_i (
            .up      (chain[g]),
            .ln      (lanes[g]),
            .dn      (chain[g+1]),
            .ev_tkn  (ev_tkn[g]),
            .ev_ntkn (ev_ntkn[g]),
            .ev_viol (ev_viol[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q <= '0;
        end else begin
            sq_q <= chain[LANES];
        end
    end

    assign sq_valid     = sq_q.valid;
    assign sq_seq       = sq_q.seq;
    assign sq_pc        = sq_q.pc;
    assign sq_incl_self = sq_q.incl_self;
    assign sq_br_taken  = sq_q.br_taken;

    sqarb_counters #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk            (clk),
        .rst            (rst),
        .ev_tkn         (ev_tkn),
        .ev_ntkn        (ev_ntkn),
        .ev_viol        (ev_viol),
        .cnt_tkn_wrong  (cnt_tkn_wrong),
        .cnt_ntkn_wrong (cnt_ntkn_wrong),
        .cnt_mispred    (cnt_mispred),
        .cnt_viol       (cnt_viol)
    );

endmodule

// File: rtl/sqarb_checker.sv
module sqarb_checker
    import sqarb_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] ln_vld,
    input logic [LANES-1:0] ln_viol,
    input logic             sq_valid,
    input logic             sq_incl_self,
    input logic             sq_br_taken,
    input logic [CNT_W-1:0] cnt_tkn_wrong,
    input logic [CNT_W-1:0] cnt_ntkn_wrong,
    input logic [CNT_W-1:0] cnt_mispred,
    input logic [CNT_W-1:0] cnt_viol
);

    logic any_vld, any_viol;
    assign any_vld  = |ln_vld;
    assign any_viol = |(ln_vld & ln_viol);

    // R2: nothing valid this cycle means no squash next cycle
    p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !any_vld |=> !sq_valid);

    // R4: a self-including squash never reports a branch direction
    p_self_no_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (sq_valid && sq_incl_self) |-> !sq_br_taken);

    // R9: total misprediction counter tracks the two split counters
    p_total_sum_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_mispred == CNT_W'(cnt_tkn_wrong + cnt_ntkn_wrong));

    // R10: violation counter moves only when a violation was reported
    p_viol_source_r10: assert property (@(posedge clk) disable iff (rst)
        !any_viol |=> $stable(cnt_viol));

    // R2: no squash can appear without a completing lane the cycle before
    p_squash_needs_lane_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sq_valid) |-> $past(any_vld));

endmodule

bind squash_arbiter sqarb_checker #(
    .LANES (LANES),
    .CNT_W (CNT_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .ln_vld         (ln_vld),
    .ln_viol        (ln_viol),
    .sq_valid       (sq_valid),
    .sq_incl_self   (sq_incl_self),
    .sq_br_taken    (sq_br_taken),
    .cnt_tkn_wrong  (cnt_tkn_wrong),
    .cnt_ntkn_wrong (cnt_ntkn_wrong),
    .cnt_mispred    (cnt_mispred),
    .cnt_viol       (cnt_viol)
);

// File: tb/squash_arbiter_tb_top.sv
`timescale 1ns/1ps
module squash_arbiter_tb_top;
    import sqarb_pkg::*;

    localparam int LANES = 4;
    localparam int CNT_W = 16;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [LANES-1:0]            ln_vld = '0;
    logic [LANES-1:0][SEQ_W-1:0] ln_seq = '0;
    logic [LANES-1:0]            ln_is_load = '0;
    logic [LANES-1:0]            ln_done = '0;
    logic [LANES-1:0]            ln_mispred = '0;
    logic [LANES-1:0]            ln_pred_tkn = '0;
    logic [LANES-1:0]            ln_act_tkn = '0;
    logic [LANES-1:0][PC_W-1:0]  ln_next_pc = '0;
    logic [LANES-1:0]            ln_viol = '0;
    logic [LANES-1:0][SEQ_W-1:0] ln_viol_seq = '0;
    logic [LANES-1:0][PC_W-1:0]  ln_viol_pc = '0;
    logic                        sq_valid;
    logic [SEQ_W-1:0]            sq_seq;
    logic [PC_W-1:0]             sq_pc;
    logic                        sq_incl_self;
    logic                        sq_br_taken;
    logic [CNT_W-1:0]            cnt_tkn_wrong, cnt_ntkn_wrong, cnt_mispred, cnt_viol;

    always #5 clk = ~clk;

    squash_arbiter #(.LANES(LANES), .CNT_W(CNT_W)) dut_i (.*);

    typedef struct {
        bit               v;
        bit [SEQ_W-1:0]   seq;
        bit [PC_W-1:0]    pc;
        bit               self_f;
        bit               tk;
        bit [CNT_W-1:0]   ct, cn, cm, cv;
        string            tag;
    } exp_t;

    exp_t           exp_q[$];
    int             n_chk = 0;
    int             n_fail = 0;
    bit [CNT_W-1:0] m_ct = 0, m_cn = 0, m_cm = 0, m_cv = 0;

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_lanes();
        ln_vld = '0; ln_seq = '0; ln_is_load = '0; ln_done = '0;
        ln_mispred = '0; ln_pred_tkn = '0; ln_act_tkn = '0; ln_next_pc = '0;
        ln_viol = '0; ln_viol_seq = '0; ln_viol_pc = '0;
    endtask

    // Model of the selection rules, written from the requirement list
    task automatic push_expected(string tag);
        exp_t e;
        bit pv; bit [SEQ_W-1:0] ps; bit [PC_W-1:0] pp; bit pself, ptk;
        pv = 0; ps = 0; pp = 0; pself = 0; ptk = 0;
        for (int i = 0; i < LANES; i++) begin
            bit look, mis;
            if (!ln_vld[i]) continue;
            look = !pv || (ps > ln_seq[i]);                 // R7
            mis  = ln_mispred[i] && !(ln_is_load[i] && !ln_done[i]); // R8
            if (look && mis) begin
                if (ln_pred_tkn[i]) m_ct++; else m_cn++;   // R9
                m_cm++;
                if (!pv || ln_seq[i] < ps) begin            // R5
                    pv = 1; ps = ln_seq[i]; pp = ln_next_pc[i]; pself = 0; ptk = ln_act_tkn[i];
                end
            end else if (ln_viol[i]) begin
                m_cv++;                                     // R10
                if (look && (!pv || ln_viol_seq[i] <= ps)) begin // R6
                    pv = 1; ps = ln_viol_seq[i]; pp = ln_viol_pc[i]; pself = 1; ptk = 0;
                end
            end
        end
        e.v = pv; e.seq = ps; e.pc = pp; e.self_f = pself; e.tk = ptk;
        e.ct = m_ct; e.cn = m_cn; e.cm = m_cm; e.cv = m_cv; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drive_cycle(string tag);
        push_expected(tag);
        @(negedge clk);
        clear_lanes();
    endtask

    task automatic set_branch(int i, int seq, bit pt, bit at, int npc);
        ln_vld[i] = 1; ln_seq[i] = SEQ_W'(seq); ln_done[i] = 1;
        ln_mispred[i] = 1; ln_pred_tkn[i] = pt; ln_act_tkn[i] = at;
        ln_next_pc[i] = PC_W'(npc);
    endtask

    task automatic set_viol(int i, int seq, int vseq, int vpc);
        ln_vld[i] = 1; ln_seq[i] = SEQ_W'(seq); ln_done[i] = 1;
        ln_viol[i] = 1; ln_viol_seq[i] = SEQ_W'(vseq); ln_viol_pc[i] = PC_W'(vpc);
    endtask

    // Monitor: compares the result registered at the preceding edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check_eq(e.tag, "sq_valid", sq_valid, e.v);
            if (e.v) begin
                check_eq(e.tag, "sq_seq", sq_seq, e.seq);
                check_eq(e.tag, "sq_pc", sq_pc, e.pc);
                check_eq(e.tag, "sq_incl_self", sq_incl_self, e.self_f);
                check_eq(e.tag, "sq_br_taken", sq_br_taken, e.tk);
            end
            check_eq("R9", "cnt_tkn_wrong", cnt_tkn_wrong, e.ct);
            check_eq("R9", "cnt_ntkn_wrong", cnt_ntkn_wrong, e.cn);
            check_eq("R9", "cnt_mispred", cnt_mispred, e.cm);
            check_eq("R10", "cnt_viol", cnt_viol, e.cv);
        end
    end

    bit finished = 0;

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_lanes();
        // drive a busy pattern during reset to show it is held off
        set_branch(0, 3, 1, 0, 'h100);
        set_viol(1, 1, 2, 'h200);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "sq_valid", sq_valid, 0);
        check_eq("R1", "cnt_mispred", cnt_mispred, 0);
        check_eq("R1", "cnt_viol", cnt_viol, 0);
        check_eq("R1", "sq_pc", sq_pc, 0);
        clear_lanes();
        rst = 0;

        // R2: idle cycle
        drive_cycle("R2");
        // R3: single branch, predicted taken, resolved not taken
        set_branch(1, 20, 1, 0, 'h1004);
        drive_cycle("R3");
        // R2: redirect does not persist
        drive_cycle("R2");
        // R4: single violation
        set_viol(2, 7, 9, 'h2200);
        drive_cycle("R4");
        // R5: younger branch first, older branch later replaces it
        set_branch(0, 30, 0, 1, 'h3000);
        set_branch(2, 12, 0, 1, 'h3300);
        drive_cycle("R5");
        // R5: equal-seq branch does not replace
        set_branch(0, 15, 0, 1, 'h4000);
        set_branch(1, 14, 1, 0, 'h4100);
        set_branch(3, 14, 0, 0, 'h4200);
        drive_cycle("R5");
        // R6: branch seq 10 then violation naming seq 10 wins
        set_branch(0, 10, 1, 1, 'h5000);
        set_viol(1, 5, 10, 'h5500);
        drive_cycle("R6");
        // R6/R7: violation first, later branch with same seq not examined
        set_viol(0, 3, 10, 'h6000);
        set_branch(1, 10, 0, 1, 'h6100);
        drive_cycle("R6");
        // R7: lane younger than pending is skipped, its violation only counted
        set_branch(0, 8, 0, 1, 'h7000);
        set_viol(1, 9, 2, 'h7700);
        drive_cycle("R7");
        // R10: examined violation younger than pending is counted, not taken
        set_branch(0, 10, 1, 0, 'h8000);
        set_viol(1, 4, 15, 'h8800);
        drive_cycle("R10");
        // R8: unexecuted load with mispredict flag is ignored
        set_branch(0, 5, 1, 1, 'h9000);
        ln_is_load[0] = 1; ln_done[0] = 0;
        drive_cycle("R8");
        // R8: executed load with mispredict flag is honoured
        set_branch(2, 6, 0, 1, 'h9100);
        ln_is_load[2] = 1;
        drive_cycle("R8");
        // R11: mispredicting lane's violation input is neither counted nor used
        set_branch(0, 11, 1, 0, 'hA000);
        ln_viol[0] = 1; ln_viol_seq[0] = 4; ln_viol_pc[0] = 'hAAAA;
        drive_cycle("R11");

        // Random traffic with narrow sequence range
        for (int c = 0; c < 300; c++) begin
            for (int i = 0; i < LANES; i++) begin
                ln_vld[i]      = ($urandom % 3) != 0;
                ln_seq[i]      = SEQ_W'($urandom % 12);
                ln_is_load[i]  = $urandom % 2;
                ln_done[i]     = $urandom % 2;
                ln_mispred[i]  = ($urandom % 3) == 0;
                ln_pred_tkn[i] = $urandom % 2;
                ln_act_tkn[i]  = $urandom % 2;
                ln_next_pc[i]  = PC_W'($urandom);
                ln_viol[i]     = ($urandom % 3) == 0;
                ln_viol_seq[i] = SEQ_W'($urandom % 12);
                ln_viol_pc[i]  = PC_W'($urandom);
            end
            drive_cycle("R5");
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule